// File: doc/BRIEF.md
# Printer carriage and page controller

This block drives the paper motion of a line printer. It holds a vertical format memory in which each entry stands for one printed line and carries twelve channel-stop bits, a line pointer into that memory, a 12-bit page counter and a column counter. A host issues one of two commands: advance a fixed number of lines, or skip forward to the next line whose entry has a chosen channel bit set. The block answers each command with a burst of newline and form-feed strobes, then a one-cycle done pulse. The pulse comes with a continue flag that says whether printing may go on.

Landing on a line whose entry has bit 0 set means a page has been completed. Each such landing decrements the page counter. When that counter reaches zero the block raises a page-zero flag and tells the host to stop. A channel search that wraps all the way round without a match marks the format memory as invalid.

Format entries, the format length and the page count are written through simple write strobes. A column-step input counts printed characters so that a skip to top-of-form can close an unfinished line first.

Top module: `carriage_ctrl`

## Requirements
- R1: After reset, busy, both strobes, done, continue and page-zero are low. The line pointer, page count, column count and format length are zero, so `fmt_ok` is low.
- R2: A command that arrives while the format length is zero produces no strobe. It is followed one cycle later by done with continue low.
- R3: An advance command (`cmd_skip`=0) of N lines, with N from 1 to 15 in `cmd_arg`, emits N newline strobes, clears the column counter and leaves the pointer at (pointer+N) modulo the length. An advance of 0 gives done with continue high and no strobes.
- R4: After an advance or a non-zero channel skip, if bit 0 of the entry at the new pointer is set, the page counter decrements modulo 4096. A result of zero sets page-zero and drives continue low. Any other result clears page-zero and drives continue high. If bit 0 is clear, continue is high and page-zero is unchanged.
- R5: A skip command (`cmd_skip`=1) to channel C steps the pointer forward with wrap and tests bit C of each entry visited. For C other than 0, when the match is found after k steps, the block emits k newlines, clears the column and leaves the pointer on the matching entry.
- R6: A skip request with `cmd_arg` above 11 behaves exactly as a skip to channel 7.
- R7: A skip to channel 0 emits one newline if the column counter is nonzero, then one form-feed strobe. It then always decrements the page counter under the zero-stop rule of R4.
- R8: If a skip tests as many entries as the length without a match, the length becomes zero and `fmt_ok` goes low. No strobe is emitted, done comes with continue low, and the pointer ends where it started.
- R9: At most one strobe is high per cycle, a newline never follows a form feed within one command, and busy stays high while strobes are issued. Done comes with busy low.
- R10: While busy, a new command, a length write and a page write are ignored.
- R11: While idle, each `col_step` pulse increments the column counter, which saturates at its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_we | input | 1 | Write strobe for one format entry |
| fmt_addr | input | 8 | Entry index for the write |
| fmt_wdata | input | 12 | Entry value; bit c is the stop bit of channel c |
| len_we | input | 1 | Write strobe for the format length; also returns the pointer to 0 |
| len_wdata | input | 8 | New length, clamped to the memory depth |
| page_we | input | 1 | Write strobe for the page counter |
| page_wdata | input | 12 | New page count |
| col_step | input | 1 | One printed character; advances the column counter |
| cmd_valid | input | 1 | Command request, taken only while idle |
| cmd_skip | input | 1 | 0 = advance lines, 1 = skip to channel |
| cmd_arg | input | 4 | Line count or channel number |
| busy | output | 1 | A command is in progress |
| nl_stb | output | 1 | Newline strobe |
| ff_stb | output | 1 | Form-feed strobe |
| done | output | 1 | One-cycle end-of-command pulse |
| cont | output | 1 | Printing may continue; valid with done |
| page_zero | output | 1 | Page counter reached zero |
| fmt_ok | output | 1 | Format length is nonzero |
| line_ptr | output | 8 | Current format pointer |
| page_cnt | output | 12 | Current page counter |
| col_cnt | output | 8 | Current column counter |

## Verification
The bench sends advances that wrap exactly onto the top-of-form entry. It also sends a channel-0 skip whose only match is the last entry of a full pass, where a controller with an off-by-one search bound would declare the format invalid instead of feeding the form. Channel-0 skips are run with the column both zero and nonzero, so that a missing or an extra leading newline shows up as a wrong strobe count. The page counter is driven down to zero and then reloaded, to catch a page-zero flag that never sets or never clears. Out-of-range channels, a search that fails and wraps the pointer back, and commands or page writes sent while busy are each checked for their effect on the pointer and on the counters.

// File: rtl/carriage_pkg.sv
package carriage_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEARCH,
        ST_EMIT,
        ST_TOF,
        ST_PRENL,
        ST_FF,
        ST_PGDEC
    } cstate_e;

    localparam int unsigned CHAN_TOF      = 0;
    localparam int unsigned CHAN_LAST     = 11;
    localparam int unsigned CHAN_FALLBACK = 7;

endpackage

// File: rtl/carriage_vfmem.sv
module carriage_vfmem #(
    parameter int unsigned DEPTH = 143,
    parameter int unsigned WIDTH = 12,
    parameter int unsigned AW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] row_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n)
                row_q[i] <= '0;
            else if (wr_en && wr_addr == AW'(i))
                row_q[i] <= wr_data;
        end
    end

    assign rd_data = (rd_addr < AW'(DEPTH)) ? row_q[rd_addr] : '0;

endmodule

// File: rtl/carriage_chan_sel.sv
module carriage_chan_sel import carriage_pkg::*; #(
    parameter int unsigned ARG_W = 4
) (
    input  logic [ARG_W-1:0] req_chan,
    output logic [ARG_W-1:0] eff_chan
);
    assign eff_chan = (req_chan > ARG_W'(CHAN_LAST)) ? ARG_W'(CHAN_FALLBACK) : req_chan;
endmodule

// File: rtl/carriage_ctrl.sv
module carriage_ctrl import carriage_pkg::*; #(
    parameter int unsigned DEPTH  = 143,
    parameter int unsigned VF_W   = 12,
    parameter int unsigned PAGE_W = 12,
    parameter int unsigned COL_W  = 8,
    parameter int unsigned ARG_W  = 4,
    localparam int unsigned AW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fmt_we,
    input  logic [AW-1:0]     fmt_addr,
    input  logic [VF_W-1:0]   fmt_wdata,
    input  logic              len_we,
    input  logic [AW-1:0]     len_wdata,
    input  logic              page_we,
    input  logic [PAGE_W-1:0] page_wdata,
    input  logic              col_step,
    input  logic              cmd_valid,
    input  logic              cmd_skip,
    input  logic [ARG_W-1:0]  cmd_arg,
    output logic              busy,
    output logic              nl_stb,
    output logic              ff_stb,
    output logic              done,
    output logic              cont,
    output logic              page_zero,
    output logic              fmt_ok,
    output logic [AW-1:0]     line_ptr,
    output logic [PAGE_W-1:0] page_cnt,
    output logic [COL_W-1:0]  col_cnt
);
    typedef struct packed {
        cstate_e           st;
        logic [AW-1:0]     ptr;
        logic [AW-1:0]     len;
        logic [AW-1:0]     cnt;
        logic [PAGE_W-1:0] page;
        logic [COL_W-1:0]  col;
        logic [ARG_W-1:0]  chan;
        logic              move;
        logic              pz;
        logic              nl;
        logic              ff;
        logic              done;
        logic              cont;
    } regs_t;

    regs_t r_q, r_d;

    logic [AW-1:0]     ptr_next;
    logic [AW-1:0]     cnt_inc;
    logic [AW-1:0]     rd_addr;
    logic [VF_W-1:0]   rd_data;
    logic [ARG_W-1:0]  chan_eff;
    logic [PAGE_W-1:0] page_dec;

    assign ptr_next = (r_q.ptr + AW'(1) >= r_q.len) ? '0 : r_q.ptr + AW'(1);
    assign cnt_inc  = r_q.cnt + AW'(1);
    assign page_dec = r_q.page - PAGE_W'(1);
    assign rd_addr  = (r_q.st == ST_SEARCH) ? ptr_next : r_q.ptr;

    carriage_vfmem #(.DEPTH(DEPTH), .WIDTH(VF_W), .AW(AW)) u_vfmem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (fmt_we),
        .wr_addr (fmt_addr),
        .wr_data (fmt_wdata),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    carriage_chan_sel #(.ARG_W(ARG_W)) u_chan_sel (
        .req_chan (cmd_arg),
        .eff_chan (chan_eff)
    );

    always_comb begin
        r_d      = r_q;
        r_d.nl   = 1'b0;
        r_d.ff   = 1'b0;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (len_we) begin
                    r_d.len = (len_wdata > AW'(DEPTH)) ? AW'(DEPTH) : len_wdata;
                    r_d.ptr = '0;
                end
                if (page_we)
                    r_d.page = page_wdata;
                if (col_step && r_q.col != '1)
                    r_d.col = r_q.col + COL_W'(1);
                if (cmd_valid) begin
                    if (r_q.len == '0) begin
                        r_d.done = 1'b1;
                        r_d.cont = 1'b0;
                    end else if (!cmd_skip) begin
                        if (cmd_arg == '0) begin
                            r_d.done = 1'b1;
                            r_d.cont = 1'b1;
                        end else begin
                            r_d.st   = ST_EMIT;
                            r_d.cnt  = {{(AW-ARG_W){1'b0}}, cmd_arg};
                            r_d.move = 1'b1;
                        end
                    end else begin
                        r_d.st   = ST_SEARCH;
                        r_d.chan = chan_eff;
                        r_d.cnt  = '0;
                    end
                end
            end
            ST_SEARCH: begin
                r_d.ptr = ptr_next;
                r_d.cnt = cnt_inc;
                if (rd_data[r_q.chan]) begin
                    if (r_q.chan != ARG_W'(CHAN_TOF)) begin
                        r_d.st   = ST_EMIT;
                        r_d.move = 1'b0;
                    end else if (r_q.col != '0) begin
                        r_d.st = ST_PRENL;
                    end else begin
                        r_d.st = ST_FF;
                    end
                end else if (cnt_inc == r_q.len) begin
                    r_d.st   = ST_IDLE;
                    r_d.len  = '0;
                    r_d.done = 1'b1;
                    r_d.cont = 1'b0;
                end
            end
            ST_EMIT: begin
                r_d.nl  = 1'b1;
                r_d.col = '0;
                r_d.cnt = r_q.cnt - AW'(1);
                if (r_q.move)
                    r_d.ptr = ptr_next;
                if (r_q.cnt == AW'(1))
                    r_d.st = ST_TOF;
            end
            ST_TOF: begin
                r_d.st   = ST_IDLE;
                r_d.done = 1'b1;
                if (rd_data[CHAN_TOF]) begin
                    r_d.page = page_dec;
                    r_d.pz   = (page_dec == '0);
                    r_d.cont = (page_dec != '0);
                end else begin
                    r_d.cont = 1'b1;
                end
            end
            ST_PRENL: begin
                r_d.nl  = 1'b1;
                r_d.col = '0;
                r_d.st  = ST_FF;
            end
            ST_FF: begin
                r_d.ff = 1'b1;
                r_d.st = ST_PGDEC;
            end
            ST_PGDEC: begin
                r_d.st   = ST_IDLE;
                r_d.done = 1'b1;
                r_d.page = page_dec;
                r_d.pz   = (page_dec == '0);
                r_d.cont = (page_dec != '0);
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign nl_stb    = r_q.nl;
    assign ff_stb    = r_q.ff;
    assign done      = r_q.done;
    assign cont      = r_q.cont;
    assign page_zero = r_q.pz;
    assign fmt_ok    = (r_q.len != '0);
    assign line_ptr  = r_q.ptr;
    assign page_cnt  = r_q.page;
    assign col_cnt   = r_q.col;

endmodule

// File: rtl/carriage_ctrl_chk.sv
module carriage_ctrl_chk #(
    parameter int unsigned COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             nl_stb,
    input logic             ff_stb,
    input logic             done,
    input logic             cont,
    input logic             page_zero,
    input logic             fmt_ok,
    input logic [COL_W-1:0] col_cnt
);
    p_single_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(nl_stb && ff_stb));

    p_strobe_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (nl_stb || ff_stb) |-> busy);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_newline_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
        nl_stb |-> (col_cnt == '0));

    p_pz_on_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(page_zero) |-> done);

    p_stop_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !cont) |-> (page_zero || !fmt_ok));

endmodule

bind carriage_ctrl carriage_ctrl_chk #(.COL_W(COL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .nl_stb    (nl_stb),
    .ff_stb    (ff_stb),
    .done      (done),
    .cont      (cont),
    .page_zero (page_zero),
    .fmt_ok    (fmt_ok),
    .col_cnt   (col_cnt)
);

// File: tb/carriage_ctrl_tb.sv
`timescale 1ns/1ps
module carriage_ctrl_tb;
    localparam int DEPTH = 143;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fmt_we = 0;
    logic [7:0]  fmt_addr = 0;
    logic [11:0] fmt_wdata = 0;
    logic        len_we = 0;
    logic [7:0]  len_wdata = 0;
    logic        page_we = 0;
    logic [11:0] page_wdata = 0;
    logic        col_step = 0;
    logic        cmd_valid = 0;
    logic        cmd_skip = 0;
    logic [3:0]  cmd_arg = 0;
    logic        busy, nl_stb, ff_stb, done, cont, page_zero, fmt_ok;
    logic [7:0]  line_ptr;
    logic [11:0] page_cnt;
    logic [7:0]  col_cnt;

    always #2.5 clk = ~clk;

    carriage_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .fmt_we(fmt_we), .fmt_addr(fmt_addr),
        .fmt_wdata(fmt_wdata), .len_we(len_we), .len_wdata(len_wdata),
        .page_we(page_we), .page_wdata(page_wdata), .col_step(col_step),
        .cmd_valid(cmd_valid), .cmd_skip(cmd_skip), .cmd_arg(cmd_arg),
        .busy(busy), .nl_stb(nl_stb), .ff_stb(ff_stb), .done(done),
        .cont(cont), .page_zero(page_zero), .fmt_ok(fmt_ok),
        .line_ptr(line_ptr), .page_cnt(page_cnt), .col_cnt(col_cnt)
    );

    int checks = 0;
    int errors = 0;
    int dones  = 0;
    bit finished = 0;

    // bench model of the block state
    int fm [DEPTH];
    int m_len = 0, m_ptr = 0, m_page = 0, m_col = 0;
    bit m_pz = 0;

    // scoreboard queues
    int    q_nl[$], q_ff[$], q_ptr[$], q_page[$], q_col[$];
    bit    q_cont[$], q_pz[$], q_ok[$];
    string q_tag[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor
    int  nl_seen = 0, ff_seen = 0;
    bit  order_bad = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (nl_stb) begin
                if (ff_seen != 0) order_bad = 1;
                nl_seen++;
            end
            if (ff_stb) ff_seen++;
            if (done) begin
                if (q_tag.size() == 0) begin
                    chk(0, "R10", "unexpected done", 1, 0);
                end else begin
                    string t;
                    t = q_tag.pop_front();
                    begin
                        int e_nl, e_ff, e_ptr, e_pg, e_col;
                        bit e_c, e_pz, e_ok;
                        e_nl = q_nl.pop_front(); e_ff = q_ff.pop_front();
                        e_ptr = q_ptr.pop_front(); e_pg = q_page.pop_front();
                        e_col = q_col.pop_front(); e_c = q_cont.pop_front();
                        e_pz = q_pz.pop_front(); e_ok = q_ok.pop_front();
                        chk(nl_seen == e_nl, t, "newlines", nl_seen, e_nl);
                        chk(ff_seen == e_ff, t, "form feeds", ff_seen, e_ff);
                        chk(cont == e_c, t, "cont", int'(cont), int'(e_c));
                        chk(page_zero == e_pz, t, "page_zero", int'(page_zero), int'(e_pz));
                        chk(fmt_ok == e_ok, t, "fmt_ok", int'(fmt_ok), int'(e_ok));
                        chk(int'(line_ptr) == e_ptr, t, "line_ptr", int'(line_ptr), e_ptr);
                        chk(int'(page_cnt) == e_pg, t, "page_cnt", int'(page_cnt), e_pg);
                        chk(int'(col_cnt) == e_col, t, "col_cnt", int'(col_cnt), e_col);
                        chk(!order_bad, "R9", "newline after form feed", int'(order_bad), 0);
                    end
                end
                nl_seen = 0; ff_seen = 0; order_bad = 0;
                dones++;
            end
        end
    end

    task automatic page_step(output bit c);
        m_page = (m_page - 1) & 12'hfff;
        m_pz = (m_page == 0);
        c = !m_pz;
    endtask

    // model of one command, pushes the expected result
    task automatic model_cmd(input bit skip, input int arg, input string tag);
        int nl = 0, ff = 0;
        bit c = 1;
        if (m_len == 0) begin
            c = 0;
        end else if (!skip) begin
            if (arg != 0) begin
                nl = arg;
                m_col = 0;
                m_ptr = (m_ptr + arg) % m_len;
                if (fm[m_ptr] & 1) page_step(c);
            end
        end else begin
            int ch, k, p;
            bit found = 0;
            ch = (arg > 11) ? 7 : arg;
            p = m_ptr;
            for (k = 1; k <= m_len; k++) begin
                p = (m_ptr + k) % m_len;
                if ((fm[p] >> ch) & 1) begin found = 1; break; end
            end
            if (!found) begin
                m_len = 0;
                c = 0;
            end else if (ch != 0) begin
                m_ptr = p;
                nl = k;
                m_col = 0;
                if (fm[m_ptr] & 1) page_step(c);
            end else begin
                m_ptr = p;
                nl = (m_col != 0) ? 1 : 0;
                m_col = 0;
                ff = 1;
                page_step(c);
            end
        end
        q_nl.push_back(nl); q_ff.push_back(ff); q_ptr.push_back(m_ptr);
        q_page.push_back(m_page); q_col.push_back(m_col); q_cont.push_back(c);
        q_pz.push_back(m_pz); q_ok.push_back(m_len != 0); q_tag.push_back(tag);
    endtask

    task automatic issue(input bit skip, input int arg, input string tag);
        int target;
        target = dones + 1;
        model_cmd(skip, arg, tag);
        @(negedge clk);
        cmd_valid = 1; cmd_skip = skip; cmd_arg = arg[3:0];
        @(negedge clk);
        cmd_valid = 0;
        wait (dones >= target);
        @(negedge clk);
    endtask

    task automatic wr_fmt(input int a, input int d);
        fm[a] = d;
        @(negedge clk);
        fmt_we = 1; fmt_addr = a[7:0]; fmt_wdata = d[11:0];
        @(negedge clk);
        fmt_we = 0;
    endtask

    task automatic wr_len(input int l);
        m_len = l; m_ptr = 0;
        @(negedge clk);
        len_we = 1; len_wdata = l[7:0];
        @(negedge clk);
        len_we = 0;
    endtask

    task automatic wr_page(input int v);
        m_page = v;
        @(negedge clk);
        page_we = 1; page_wdata = v[11:0];
        @(negedge clk);
        page_we = 0;
    endtask

    task automatic col_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            col_step = 1;
            if (m_col < 255) m_col++;
        end
        @(negedge clk);
        col_step = 0;
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) fm[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !nl_stb && !ff_stb && !done, "R1", "control outputs", int'(busy), 0);
        chk(!cont && !page_zero && !fmt_ok, "R1", "flags", int'(fmt_ok), 0);
        chk(line_ptr == 0 && page_cnt == 0 && col_cnt == 0, "R1", "counters",
            int'(page_cnt), 0);

        // R2 command with no format
        issue(0, 3, "R2");

        // load format: TOF at 0, ch2 at 3, ch7 at 6, ch1 at 9
        wr_fmt(0, 12'h001);
        wr_fmt(3, 12'h004);
        wr_fmt(6, 12'h080);
        wr_fmt(9, 12'h002);
        wr_len(12);
        wr_page(3);

        issue(0, 0, "R3");          // advance of zero
        issue(0, 2, "R3");          // ptr 2
        col_pulses(5);
        chk(col_cnt == 5, "R11", "column count", int'(col_cnt), 5);
        issue(1, 2, "R5");          // ch2 found at 3 after 1 step
        issue(1, 15, "R6");         // treated as ch7, lands on 6
        issue(0, 7, "R3");          // 6+7 wraps to 1
        issue(0, 11, "R4");         // wraps onto 0, TOF, page 3->2
        col_pulses(3);
        issue(1, 0, "R7");          // full pass to 0, leading newline, page 2->1
        issue(1, 0, "R7");          // column zero, page 1->0 stop
        wr_page(2);
        issue(0, 12, "R4");         // back to 0, page 2->1, flag clears
        issue(1, 2, "R5");          // 0 -> 3

        // R10 command and page write during busy are ignored
        begin
            int target;
            target = dones + 1;
            model_cmd(0, 5, "R10");
            @(negedge clk);
            cmd_valid = 1; cmd_skip = 0; cmd_arg = 4'd5;
            @(negedge clk);
            cmd_skip = 1; cmd_arg = 4'd0;
            page_we = 1; page_wdata = 12'd7;
            len_we = 1; len_wdata = 8'd4;
            @(negedge clk);
            cmd_valid = 0; page_we = 0; len_we = 0;
            wait (dones >= target);
            repeat (30) @(negedge clk);
            chk(dones == target, "R10", "done count", dones, target);
            chk(int'(page_cnt) == m_page, "R10", "page after busy write", int'(page_cnt), m_page);
            chk(fmt_ok == 1'b1, "R10", "length after busy write", int'(fmt_ok), 1);
        end

        issue(1, 2, "R5");          // 8 wraps to 3 after 7 steps
        issue(1, 5, "R8");          // no ch5 anywhere: invalid
        issue(0, 1, "R2");          // length now zero
        chk(q_tag.size() == 0, "R9", "pending expectations", q_tag.size(), 0);
        finished = 1;
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            chk(0, "R9", "watchdog expired", 1, 0);
            summary();
        end
    end

endmodule